// File: doc/BRIEF.md
# DDR Activate-to-Read Command Scheduler

This block sits on the controller side of a four-bank DDR SDRAM. It takes one read request at a time: a bank, a row, a column and an auto-precharge flag. It turns that request into the command sequence the memory needs. When the target bank has no open row, it first opens one with ACTIVATE. It then waits out the row-to-column delay before it issues the READ. It also keeps consecutive ACTIVATE commands at least the activate-to-activate delay apart. Every cycle that carries neither command carries NOP.

Both delays are given as picosecond minimums together with the clock period. Each is converted into a clock count by rounding the ratio up to the next whole cycle. The block remembers, per bank, whether a row is open and which row it is. A READ whose auto-precharge flag is set marks that bank closed. Requests are taken in order through a valid/ready handshake. Ready rises only in the cycle whose decision is the READ. Commands, bank address and the shared address bus come out of a register, one cycle after that decision.

Top module: `ddr_act_rd_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, the command is NOP, the bank and address outputs are zero, and ready is low.
- R2: The row-to-column and activate-to-activate clock counts equal the delay divided by the clock period, rounded up, with a minimum of one. With a 7500 ps clock, 15000 ps gives 2 and 18000 ps gives 3.
- R3: A valid request to a bank with no open row produces, one cycle later, an ACTIVATE command. It carries that bank on the bank output and the row on the address bus. The request is not accepted.
- R4: A READ to a bank appears no fewer than the row-to-column count of cycles after that bank's ACTIVATE appeared.
- R5: Two ACTIVATE commands appear no fewer than the activate-to-activate count of cycles apart, whatever their banks.
- R6: A request to an open bank on its open row is accepted (ready high) once the row-to-column count has elapsed. One cycle later a READ appears with that bank. Address bits 9:0 carry the column, bit 10 carries the auto-precharge flag, and bits 12:11 are zero.
- R7: A READ with the flag low leaves the row open, so further reads to it issue on consecutive cycles with no new ACTIVATE. A READ with the flag high closes the bank, so the next request to it begins with an ACTIVATE.
- R8: A request to an open bank whose row differs from the open row is not accepted and produces NOP for as long as it is presented.
- R9: Commands are encoded as {RAS#, CAS#, WE#}: ACTIVATE 011, READ 101, NOP 111. A NOP carries zero on the bank and address outputs.
- R10: Ready is high only in a cycle whose decision is a READ, and every READ follows such a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A read request is presented |
| req_ready | output | 1 | Request accepted this cycle (READ decided) |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| req_ap | input | 1 | Auto-precharge: close the row after the READ |
| cmd_code | output | 3 | {RAS#, CAS#, WE#} command code |
| cmd_ba | output | 2 | Bank address of the command |
| cmd_addr | output | 13 | Row on ACTIVATE, column with auto-precharge bit on READ |

## Verification
The interaction most likely to break is this one: the row-to-column wait for one bank ends in the same cycle in which the activate-to-activate window from another bank's ACTIVATE is still running. Both timers then run at once, and only one command per cycle may result. The bench provokes this by starting an ACTIVATE and then switching the head request to a second closed bank. The READ to the first bank then lands inside the spacing window. A long pseudo-random stream mixes idle gaps, auto-precharge closures and back-to-back reads. A timestamp model in the bench predicts every cycle's command, bank, address and ready. Each prediction is computed from the edge numbers of earlier ACTIVATE commands, never from counters.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BA_W      = $clog2(NUM_BANKS);
    localparam int ADDR_W    = 13;
    localparam int COL_W     = 10;
    localparam int AP_BIT    = 10;
    localparam int CNT_W     = 4;

    // {RAS#, CAS#, WE#}
    typedef enum logic [2:0] {
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef struct packed {
        cmd_e              op;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    localparam cmd_t CMD_IDLE = '{op: CMD_NOP, ba: '0, addr: '0};

    // Round a picosecond minimum up to whole clocks, clamped to 1..15.
    function automatic logic [CNT_W-1:0] clk_ceil(input int unsigned dly_ps,
                                                 input int unsigned tck_ps);
        int unsigned q;
        q = (dly_ps + tck_ps - 1) / tck_ps;
        if (q < 1) q = 1;
        if (q > (1 << CNT_W) - 1) q = (1 << CNT_W) - 1;
        return q[CNT_W-1:0];
    endfunction

    function automatic logic [ADDR_W-1:0] rd_addr(input logic [COL_W-1:0] col,
                                                 input logic ap);
        logic [ADDR_W-1:0] a;
        a = '0;
        a[COL_W-1:0] = col;
        a[AP_BIT]    = ap;
        return a;
    endfunction

endpackage

// File: rtl/ddr_delay_timer.sv
module ddr_delay_timer #(
    parameter int               CNT_W = 4,
    parameter logic [CNT_W-1:0] SPAN  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);
    localparam logic [CNT_W-1:0] RELOAD = SPAN - 1'b1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= RELOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
    import ddr_sched_pkg::*;
#(
    parameter logic [CNT_W-1:0] TRCD = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic              close,
    input  logic [ADDR_W-1:0] row_in,
    output logic              is_open,
    output logic [ADDR_W-1:0] open_row,
    output logic              col_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            is_open  <= 1'b0;
            open_row <= '0;
        end else if (act) begin
            is_open  <= 1'b1;
            open_row <= row_in;
        end else if (close) begin
            is_open  <= 1'b0;
        end
    end

    ddr_delay_timer #(.CNT_W(CNT_W), .SPAN(TRCD)) u_rcd (
        .clk    (clk),
        .rst    (rst),
        .start  (act),
        .expired(col_ok)
    );
endmodule

// File: rtl/ddr_act_rd_sched.sv
module ddr_act_rd_sched
    import ddr_sched_pkg::*;
#(
    parameter int unsigned TCK_PS  = 5000,
    parameter int unsigned TRCD_PS = 15000,
    parameter int unsigned TRRD_PS = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BA_W-1:0]   req_bank,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    output logic [2:0]        cmd_code,
    output logic [BA_W-1:0]   cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr
);
    localparam logic [CNT_W-1:0] TRCD_CLK = clk_ceil(TRCD_PS, TCK_PS);
    localparam logic [CNT_W-1:0] TRRD_CLK = clk_ceil(TRRD_PS, TCK_PS);

    logic [NUM_BANKS-1:0] act_vec, close_vec, open_vec, col_ok_vec;
    logic [ADDR_W-1:0]    row_arr [NUM_BANKS];
    logic                 rrd_ok;
    logic                 do_act, do_rd, row_hit;
    cmd_t                 nxt, cur;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign act_vec[b]   = do_act && (req_bank == BA_W'(b));
        assign close_vec[b] = do_rd && req_ap && (req_bank == BA_W'(b));

        ddr_bank_track #(.TRCD(TRCD_CLK)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .act     (act_vec[b]),
            .close   (close_vec[b]),
            .row_in  (req_row),
            .is_open (open_vec[b]),
            .open_row(row_arr[b]),
            .col_ok  (col_ok_vec[b])
        );
    end

    ddr_delay_timer #(.CNT_W(CNT_W), .SPAN(TRRD_CLK)) u_rrd (
        .clk    (clk),
        .rst    (rst),
        .start  (do_act),
        .expired(rrd_ok)
    );

    assign row_hit = open_vec[req_bank] && (row_arr[req_bank] == req_row);
    assign do_rd   = req_valid && row_hit && col_ok_vec[req_bank];
    assign do_act  = req_valid && !open_vec[req_bank] && rrd_ok;

    always_comb begin
        nxt = CMD_IDLE;
        if (do_rd) begin
            nxt.op   = CMD_RD;
            nxt.ba   = req_bank;
            nxt.addr = rd_addr(req_col, req_ap);
        end else if (do_act) begin
            nxt.op   = CMD_ACT;
            nxt.ba   = req_bank;
            nxt.addr = req_row;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= CMD_IDLE;
        else     cur <= nxt;
    end

    assign req_ready = do_rd;
    assign cmd_code  = cur.op;
    assign cmd_ba    = cur.ba;
    assign cmd_addr  = cur.addr;
endmodule

// File: rtl/ddr_act_rd_sched_chk.sv
module ddr_act_rd_sched_chk
    import ddr_sched_pkg::*;
#(
    parameter logic [CNT_W-1:0] TRCD = 1,
    parameter logic [CNT_W-1:0] TRRD = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [BA_W-1:0]   req_bank,
    input logic [2:0]        cmd_code,
    input logic [BA_W-1:0]   cmd_ba,
    input logic [ADDR_W-1:0] cmd_addr
);
    localparam logic [4:0] SAT = 5'd31;

    logic [4:0]           since_act [NUM_BANKS];
    logic [4:0]           since_any;
    logic [NUM_BANKS-1:0] seen_open;

    wire is_act = (cmd_code == CMD_ACT);
    wire is_rd  = (cmd_code == CMD_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_any <= SAT;
            seen_open <= '0;
            for (int b = 0; b < NUM_BANKS; b++) since_act[b] <= SAT;
        end else begin
            since_any <= is_act ? 5'd1 : ((since_any == SAT) ? SAT : since_any + 5'd1);
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (is_act && cmd_ba == BA_W'(b))
                    since_act[b] <= 5'd1;
                else if (since_act[b] != SAT)
                    since_act[b] <= since_act[b] + 5'd1;
                if (is_act && cmd_ba == BA_W'(b))
                    seen_open[b] <= 1'b1;
                else if (is_rd && cmd_ba == BA_W'(b) && cmd_addr[AP_BIT])
                    seen_open[b] <= 1'b0;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rcd
        assert_rcd_window_R4: assert property (@(posedge clk) disable iff (rst)
            (is_rd && cmd_ba == BA_W'(b)) |-> (since_act[b] >= {1'b0, TRCD}));
    end

    assert_rrd_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (since_any >= {1'b0, TRRD}));

    assert_read_needs_open_R7: assert property (@(posedge clk) disable iff (rst)
        is_rd |-> seen_open[cmd_ba]);

    assert_act_needs_closed_R3: assert property (@(posedge clk) disable iff (rst)
        is_act |-> !seen_open[cmd_ba]);

    assert_legal_code_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_ACT) || (cmd_code == CMD_RD) || (cmd_code == CMD_NOP));

    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == CMD_NOP) |-> (cmd_ba == '0 && cmd_addr == '0));

    assert_accept_gives_read_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (is_rd && cmd_ba == $past(req_bank)));

    assert_read_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        is_rd |-> $past(req_valid && req_ready));

    assert_read_addr_top_R6: assert property (@(posedge clk) disable iff (rst)
        is_rd |-> (cmd_addr[ADDR_W-1:AP_BIT+1] == '0));
endmodule

bind ddr_act_rd_sched ddr_act_rd_sched_chk #(.TRCD(TRCD_CLK), .TRRD(TRRD_CLK)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_bank (req_bank),
    .cmd_code (cmd_code),
    .cmd_ba   (cmd_ba),
    .cmd_addr (cmd_addr)
);

// File: tb/tb_ddr_act_rd_sched.sv
module tb_ddr_act_rd_sched;
    localparam int TCK  = 7500;
    localparam int RCDP = 15000;
    localparam int RRDP = 18000;
    // R2: rounded-up clock counts, computed here from the picosecond values
    localparam int T_RCD = (RCDP + TCK - 1) / TCK;   // 2
    localparam int T_RRD = (RRDP + TCK - 1) / TCK;   // 3

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_ap = 1'b0;
    logic [2:0]  cmd_code;
    logic [1:0]  cmd_ba;
    logic [12:0] cmd_addr;

    always #10 clk = ~clk;   // 50 MHz

    ddr_act_rd_sched #(.TCK_PS(TCK), .TRCD_PS(RCDP), .TRRD_PS(RRDP)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_ap(req_ap),
        .cmd_code(cmd_code), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // timestamp model
    int          cyc = 0;
    bit          m_open [4];
    logic [12:0] m_row  [4];
    int          m_act  [4];
    int          m_last_act = -100;
    logic        e_ready;
    logic [2:0]  e_code;
    logic [1:0]  e_ba;
    logic [12:0] e_addr;

    task automatic check3(input string tag, input logic [2:0] c, input logic [1:0] b,
                          input logic [12:0] a);
        vectors++;
        if (cmd_code !== c || cmd_ba !== b || cmd_addr !== a) begin
            miscompares++;
            $display("FAIL %s edge %0d: code/ba/addr = %b/%0d/%h, expected %b/%0d/%h",
                     tag, cyc, cmd_code, cmd_ba, cmd_addr, c, b, a);
        end
    endtask

    // one cycle: drive, predict, check ready, clock, check outputs
    task automatic step(input logic v, input logic [1:0] b, input logic [12:0] row,
                        input logic [9:0] col, input logic ap, output logic acc);
        string tag;
        req_valid = v; req_bank = b; req_row = row; req_col = col; req_ap = ap;
        #1;
        e_ready = 1'b0; e_code = 3'b111; e_ba = '0; e_addr = '0; tag = "R9 R8";
        if (v) begin
            if (!m_open[b]) begin
                if (cyc - m_last_act >= T_RRD) begin
                    e_code = 3'b011; e_ba = b; e_addr = row; tag = "R3 R5 R2";
                    m_open[b] = 1'b1; m_row[b] = row; m_act[b] = cyc; m_last_act = cyc;
                end else tag = "R5 R2";
            end else if (m_row[b] == row) begin
                if (cyc - m_act[b] >= T_RCD) begin
                    e_ready = 1'b1; e_code = 3'b101; e_ba = b;
                    e_addr = {2'b00, ap, col}; tag = "R4 R6 R7 R2";
                    if (ap) m_open[b] = 1'b0;
                end else tag = "R4 R2";
            end
        end
        vectors++;
        if (req_ready !== e_ready) begin
            miscompares++;
            $display("FAIL R10 edge %0d: ready = %b, expected %b", cyc, req_ready, e_ready);
        end
        acc = e_ready;
        @(posedge clk);
        @(negedge clk);
        check3(tag, e_code, e_ba, e_addr);
        cyc++;
    endtask

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin : main
        logic acc;
        logic [31:0] lf;
        bit p_v;
        logic [1:0] p_b;
        logic [12:0] p_r;
        logic [9:0] p_c;
        logic p_a;
        for (int b = 0; b < 4; b++) begin m_open[b] = 1'b0; m_row[b] = '0; m_act[b] = -100; end

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        vectors++;
        if (req_ready !== 1'b0) begin
            miscompares++;
            $display("FAIL R1: ready = %b during reset, expected 0", req_ready);
        end
        check3("R1", 3'b111, 2'd0, 13'd0);
        rst = 1'b0;
        check3("R1", 3'b111, 2'd0, 13'd0);

        // R5: activate to bank 0, then switch the head request to closed bank 1
        step(1, 2'd0, 13'h005, 10'h012, 0, acc);
        step(1, 2'd1, 13'h007, 10'h020, 0, acc);   // held by spacing window
        step(1, 2'd0, 13'h005, 10'h012, 0, acc);   // R4: bank 0 read lands in window
        step(1, 2'd1, 13'h007, 10'h020, 0, acc);   // R5: bank 1 ACT at edge 3
        // R7: back-to-back reads to the open bank 0 row
        for (int i = 0; i < 4; i++) step(1, 2'd0, 13'h005, 10'(i * 3), 0, acc);
        // R7: close bank 0 with auto-precharge, then reopen
        step(1, 2'd0, 13'h005, 10'h3ff, 1, acc);
        step(1, 2'd0, 13'h005, 10'h001, 0, acc);   // expect ACT again
        // R8: bank 1 open on row 7; a different row is refused
        for (int i = 0; i < 3; i++) step(1, 2'd1, 13'h008, 10'h002, 0, acc);
        step(0, 2'd0, 13'h000, 10'h000, 0, acc);
        for (int i = 0; i < 3; i++) step(1, 2'd0, 13'h005, 10'h001, 0, acc);

        // sweep over a long pseudo-random request stream
        lf = 32'h1ACE_5EED;
        p_v = 1'b0; p_b = '0; p_r = '0; p_c = '0; p_a = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            if (!p_v) begin
                lf = xs(lf);
                if (lf[31:30] != 2'b00) begin
                    p_v = 1'b1;
                    p_b = lf[1:0];
                    p_r = m_open[lf[1:0]] ? m_row[lf[1:0]] : {11'd0, lf[3:2]};
                    p_c = lf[13:4];
                    p_a = lf[14] & lf[15];
                end
            end
            step(p_v, p_b, p_r, p_c, p_a, acc);
            if (acc) p_v = 1'b0;
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule